// File: doc/BRIEF.md
# I2C Channel-Select Control Register

This block is the digital control part of a four-way I2C bus switch. It acts as an I2C target on the upstream bus. It watches SCL and SDA through a system-clock oversampler and recognises START, STOP, its own 7-bit address, the direction bit and data bytes. A write transaction loads a channel mask. The mask does not reach the four channel-enable outputs until the controller ends the transaction with STOP. The switch therefore connects or disconnects downstream segments only while the bus is idle and both lines are high.

A read transaction returns one status byte. The upper half holds the four interrupt inputs and the lower half holds the channel selection that is currently active. The target drives SDA only by pulling it low, through `sda_pull`. The analog pass gates and any level shifting sit outside this block and take `chan_en` as their control.

Top module: `i2c_chsel_ctrl`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal the fixed prefix 5'b11100 followed by `addr_strap[1:0]`. Bit 0 of that byte selects the direction: 0 is write, 1 is read. Any other address gets no acknowledge, and the rest of that transaction has no effect.
- R2: In a write transaction the target pulls SDA low in the acknowledge slot of every data byte.
- R3: Bit n (n = 0..3) of a written data byte enables channel n. Bits 7..4 of the byte are ignored.
- R4: Any mask can be applied, from 4'h0 up to 4'hF, with several channels enabled together.
- R5: A written mask leaves `chan_en` unchanged until a STOP is detected. The mask is then applied and `chan_en` changes only at that STOP.
- R6: A read returns {irq_in[3:0], active mask[3:0]} most significant bit first. In the acknowledge slot that follows the byte, the target releases SDA.
- R7: While `rst_n` is low, `chan_en` is 4'h0 and `sda_pull` is 0, and any pending mask is discarded. A STOP after reset therefore applies nothing.
- R8: A START detected after a write and before its STOP discards the pending mask. `chan_en` keeps its value.
- R9: When a transaction writes several data bytes, the last byte written before the STOP is the one applied.
- R10: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. Both are judged on the synchronised samples. On either condition the target releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| scl_in | input | 1 | Sensed level of the upstream SCL line |
| sda_in | input | 1 | Sensed level of the upstream SDA line |
| addr_strap | input | 2 | Pin-strapped low bits of the target address |
| irq_in | input | 4 | Interrupt status of the four downstream segments, 1 = asserted |
| sda_pull | output | 1 | 1 pulls the upstream SDA line low |
| chan_en | output | 4 | Enable for each downstream channel, bit n enables channel n |

## Verification
The embedded properties assume the controller follows the I2C rules. SDA changes only while SCL is low, except at START and STOP. Each SCL phase lasts several system clocks, longer than the two-flop synchroniser delay. No START or STOP is attempted while the target holds SDA low. The bench drives a modelled open-drain bus with quarter-bit phases of ten clocks. It moves SDA only in the middle of the SCL low phase and ends every read with a NACK before the STOP. Random masks, interrupt values and address patterns stay inside these rules. Directed cases cover repeated START, several bytes in one write, a foreign address and reset in the middle of a transaction.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;
  localparam int unsigned NCH    = 4;
  localparam int unsigned BYTE_W = 2 * NCH;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AWAIT,
    ST_AACK,
    ST_WDATA,
    ST_WWAIT,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_RNEXT
  } tgt_state_e;
endpackage

// File: rtl/i2c_chsel_sync.sv
module i2c_chsel_sync #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] stg_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '1;
      else         stg_q <= {stg_q[DEPTH-2:0], d_i[b]};
    end
    assign q_o[b] = stg_q[DEPTH-1];
  end
endmodule

// File: rtl/i2c_chsel_cond.sv
module i2c_chsel_cond (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  assign start_o    = scl_s_i & scl_prev_q & sda_prev_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_prev_q & ~sda_prev_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_prev_q;
  assign scl_fall_o = ~scl_s_i & scl_prev_q;
endmodule

// File: rtl/i2c_chsel_target.sv
module i2c_chsel_target
  import i2c_chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           stop_i,
  input  logic           scl_rise_i,
  input  logic           scl_fall_i,
  input  logic           sda_s_i,
  input  logic [1:0]     strap_i,
  input  logic [NCH-1:0] irq_i,
  output logic           pull_o,
  output logic [NCH-1:0] active_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic [NCH-1:0]    pend_q, pend_d;
  logic              pvld_q, pvld_d;
  logic [NCH-1:0]    act_q, act_d;
  logic              pull_q, pull_d;
  logic [6:0]        own_addr;
  logic [BYTE_W-1:0] status_byte;

  assign own_addr    = {ADDR_PREFIX, strap_i};
  assign status_byte = {irq_i, act_q};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    pend_d  = pend_q;
    pvld_d  = pvld_q;
    act_d   = act_q;
    pull_d  = pull_q;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pvld_d  = 1'b0;
      pull_d  = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      if (pvld_q) begin
        act_d  = pend_q;
        pvld_d = 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise_i) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            if (sh_q[6:0] == own_addr) begin
              rw_d    = sda_s_i;
              state_d = ST_AWAIT;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AWAIT: if (scl_fall_i) begin
          pull_d  = 1'b1;
          state_d = ST_AACK;
        end
        ST_AACK, ST_RNEXT: if (scl_fall_i) begin
          cnt_d = '0;
          if (state_q == ST_RNEXT || rw_q) begin
            sh_d    = status_byte;
            pull_d  = ~status_byte[BYTE_W-1];
            state_d = ST_RDATA;
          end else begin
            pull_d  = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA: if (scl_rise_i) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            pend_d  = {sh_q[NCH-2:0], sda_s_i};
            pvld_d  = 1'b1;
            state_d = ST_WWAIT;
          end
        end
        ST_WWAIT: if (scl_fall_i) begin
          pull_d  = 1'b1;
          state_d = ST_WACK;
        end
        ST_WACK: if (scl_fall_i) begin
          pull_d  = 1'b0;
          cnt_d   = '0;
          state_d = ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt_q == FULL_CNT) begin
              pull_d  = 1'b0;
              state_d = ST_RACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: if (scl_rise_i) begin
          state_d = sda_s_i ? ST_IDLE : ST_RNEXT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      pend_q  <= '0;
      pvld_q  <= 1'b0;
      act_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      pend_q  <= pend_d;
      pvld_q  <= pvld_d;
      act_q   <= act_d;
      pull_q  <= pull_d;
    end
  end

  assign pull_o   = pull_q;
  assign active_o = act_q;

  // R5
  act_only_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !stop_i |=> $stable(act_q));
  // R8
  start_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |=> !pvld_q);
  // R10
  stop_releases_sda_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_i |=> !pull_q);
  // R5
  pend_in_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pvld_q |-> (state_q inside {ST_WDATA, ST_WWAIT, ST_WACK}));
  // R1
  idle_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pull_q);
endmodule

// File: rtl/i2c_chsel_ctrl.sv
module i2c_chsel_ctrl
  import i2c_chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_in,
  input  logic           sda_in,
  input  logic [1:0]     addr_strap,
  input  logic [NCH-1:0] irq_in,
  output logic           sda_pull,
  output logic [NCH-1:0] chan_en
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] bus_s;
  logic       start, stop, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_chsel_sync #(.W(2), .DEPTH(2)) u_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .d_i    ({scl_in, sda_in}),
    .q_o    (bus_s)
  );

  i2c_chsel_cond u_cond (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2c_chsel_target #(.ADDR_PREFIX(ADDR_PREFIX)) u_tgt (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_s_i    (bus_s[0]),
    .strap_i    (addr_strap),
    .irq_i      (irq_in),
    .pull_o     (sda_pull),
    .active_o   (chan_en)
  );

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0 && !sda_pull));
endmodule

// File: tb/i2c_chsel_ctrl_test.sv
module i2c_chsel_ctrl_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_drv, sda_drv;
  logic [1:0] addr_strap;
  logic [3:0] irq_in;
  logic       sda_pull;
  logic [3:0] chan_en;
  wire        sda_line = sda_drv & ~sda_pull;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [3:0] model_act;

  always #2 clk = ~clk;

  i2c_chsel_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_drv),
    .sda_in     (sda_line),
    .addr_strap (addr_strap),
    .irq_in     (irq_in),
    .sda_pull   (sda_pull),
    .chan_en    (chan_en)
  );

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rd);
    return {5'b11100, s, rd};
  endfunction

  function automatic logic [7:0] status_of(input logic [3:0] irq, input logic [3:0] act);
    return {irq, act};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b;    tick(Q);
    scl_drv = 1'b1; tick(2 * Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    b = sda_line;   tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(nack);
  endtask

  task automatic wr_txn(input logic [7:0] d);
    logic a0, a1;
    bus_start();
    put_byte(addr_byte(addr_strap, 1'b0), a0);
    check(a0 == 1'b0, "R1 addr ack on write", a0, 0);
    put_byte(d, a1);
    check(a1 == 1'b0, "R2 data ack", a1, 0);
    check(chan_en == model_act, "R5 no change before stop", chan_en, model_act);
    bus_stop();
    model_act = d[3:0];
    check(chan_en == model_act, "R3 R4 applied at stop", chan_en, model_act);
  endtask

  task automatic rd_txn();
    logic a0;
    logic [7:0] v;
    bus_start();
    put_byte(addr_byte(addr_strap, 1'b1), a0);
    check(a0 == 1'b0, "R1 addr ack on read", a0, 0);
    get_byte(v, 1'b1);
    check(v == status_of(irq_in, model_act), "R6 read status", v, status_of(irq_in, model_act));
    check(sda_pull == 1'b0, "R6 released after byte", sda_pull, 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
    addr_strap = 2'b01; irq_in = 4'h0; model_act = 4'h0;
    tick(5);
    check(chan_en == 4'h0, "R7 reset chan_en", chan_en, 0);
    check(sda_pull == 1'b0, "R7 reset sda_pull", sda_pull, 0);
    rst_n = 1'b1; tick(5);

    // R4 extremes, R3 upper bits ignored
    wr_txn(8'h0F);
    wr_txn(8'h00);
    wr_txn(8'hA5);
    irq_in = 4'h9;
    rd_txn();

    // R1 foreign address: no ack, no effect
    bus_start();
    put_byte({5'b11100, ~addr_strap, 1'b0}, a0);
    check(a0 == 1'b1, "R1 foreign addr nack", a0, 1);
    put_byte(8'h03, a1);
    check(a1 == 1'b1, "R1 foreign data ignored", a1, 1);
    bus_stop();
    check(chan_en == model_act, "R1 foreign no effect", chan_en, model_act);

    // R8 repeated start aborts pending write
    bus_start();
    put_byte(addr_byte(addr_strap, 1'b0), a0);
    put_byte(8'h0C, a1);
    bus_start();
    put_byte(addr_byte(addr_strap, 1'b1), a0);
    get_byte(d, 1'b1);
    check(d == status_of(irq_in, model_act), "R8 read after abort", d, status_of(irq_in, model_act));
    bus_stop();
    check(chan_en == model_act, "R8 pending dropped", chan_en, model_act);

    // R9 several bytes, last wins
    bus_start();
    put_byte(addr_byte(addr_strap, 1'b0), a0);
    put_byte(8'h01, a1);
    put_byte(8'h36, a2);
    check(a2 == 1'b0, "R2 second byte ack", a2, 0);
    check(chan_en == model_act, "R9 unchanged before stop", chan_en, model_act);
    bus_stop();
    model_act = 4'h6;
    check(chan_en == model_act, "R9 last byte applied", chan_en, model_act);

    // R7 reset mid-write clears pending and active
    bus_start();
    put_byte(addr_byte(addr_strap, 1'b0), a0);
    put_byte(8'h0B, a1);
    rst_n = 1'b0; tick(3);
    check(chan_en == 4'h0, "R7 reset mid transaction", chan_en, 0);
    rst_n = 1'b1; tick(5);
    bus_stop();
    model_act = 4'h0;
    check(chan_en == 4'h0, "R7 pending discarded", chan_en, 0);

    // R10 start/stop recognised with another strap value
    addr_strap = 2'b10;
    wr_txn(8'h79);

    // random mix
    for (int k = 0; k < 30; k++) begin
      addr_strap = 2'($urandom);
      irq_in     = 4'($urandom);
      d          = 8'($urandom);
      wr_txn(d);
      if (k % 3 == 0) rd_txn();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule